// File: doc/BRIEF.md
# SPI Interrupt and DMA Request Logic

This block holds the status flags of an SPI port and turns them into a single interrupt pulse and a pair of DMA request lines. It sits next to the shift engine, which reports its events to the block as strobes: the transmit holding register moved into the shift register, a character finished, a serial-clock edge occurred, or an error was detected. It also reports the slave-select level. Software or a DMA controller clears the flags again. Software does this through register accesses, which arrive as strobes. The DMA does it through acknowledge inputs.

A two-bit mode field turns the port off or selects receive-only, transmit-only or full-duplex operation. A one-direction mode hides the interrupts, requests and end-of-frame indications of the unused direction. A stall timer raises an abort error when slave select is held while the serial clock stops. While the port is off, a baud-generator tick can still raise the interrupt, so the baud generator can serve as a general-purpose timer.

Top module: `spi_irq_dma_ctl`

## Requirements
- R1: `irq` is high for exactly one cycle, in the cycle after any enabled interrupt source goes from clear to set. The sources are the five error bits, plus `tx_empty` and `rx_full` as gated by R4 and R10.
- R2: `tx_empty` sets on `ld_strobe`. It clears on `txd_wr` or `tx_ack`, with clearing winning over setting. It is forced to 0 while `mode` is 2'b00, and reset leaves it at 0.
- R3: `rx_full` sets on `char_done`. It clears on `rxd_rd` or `rx_ack`, with setting winning over clearing. It is forced to 0 while `mode` is 2'b00.
- R4: `mode` encodings are 2'b00 off, 2'b01 receive-only, 2'b10 transmit-only and 2'b11 full duplex. Bit 1 enables the transmit interrupt, `tx_req` and `tx_eof`. Bit 0 enables the receive interrupt, `rx_req` and `rx_eof`.
- R5: `err_flags` bit positions are 0 overrun, 1 underrun, 2 collision, 3 abort and 4 slave-select violation. Each bit sets from its detection while `mode` is not 2'b00. It stays set until a 1 is written to the same bit of `err_clr`. A detection in the same cycle as the clear wins.
- R6: the abort bit sets after STALL_CYCLES consecutive cycles in which the port is on, `ss_active` is high and `sck_edge` is low. It sets once per stall. A serial-clock edge or a slave-select deassertion restarts the count.
- R7: `tx_req` equals `tx_empty` in the transmit modes and `rx_req` equals `rx_full` in the receive modes. An acknowledge drops its request in the next cycle.
- R8: `tx_eof` and `rx_eof` pulse for one cycle, one cycle after `ss_active` is first seen low following a high, each in its own direction's modes.
- R9: while `mode` is 2'b00 and `timer_irq_en` is high, `brg_tick` gives an `irq` pulse in the next cycle and changes no status bit.
- R10: `data_irq_en` gates the `tx_empty` and `rx_full` interrupt sources. It does not gate the error sources.
- R11: in receive-only mode `tx_empty` still follows R2, so a transmit-data write is still needed for each character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Enable and direction field |
| data_irq_en | input | 1 | Enables the data-flag interrupt sources |
| timer_irq_en | input | 1 | Enables the baud-timer interrupt while off |
| brg_tick | input | 1 | Baud-generator timeout strobe |
| txd_wr | input | 1 | Software write of the transmit data register |
| rxd_rd | input | 1 | Software read of the receive data register |
| ld_strobe | input | 1 | Transmit holding register loaded into the shifter |
| char_done | input | 1 | Character transfer complete |
| ss_active | input | 1 | Slave select asserted |
| sck_edge | input | 1 | Serial-clock edge seen |
| err_ovr_det | input | 1 | Receive overrun detected |
| err_und_det | input | 1 | Transmit underrun detected |
| err_col_det | input | 1 | Collision detected |
| err_ssv_det | input | 1 | Slave-select violation detected |
| err_clr | input | 5 | Write-one-to-clear strobes for the error bits |
| tx_ack | input | 1 | DMA acknowledge for the transmit request |
| rx_ack | input | 1 | DMA acknowledge for the receive request |
| tx_empty | output | 1 | Transmit data register empty |
| rx_full | output | 1 | Receive data register full |
| err_flags | output | 5 | Sticky error bits |
| irq | output | 1 | One-cycle interrupt pulse |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_eof | output | 1 | Transmit end-of-frame indication |
| rx_eof | output | 1 | Receive end-of-frame indication |

## Verification
The assertions check the following on every cycle:
- a rise of an enabled transmit flag produces the pulse;
- a transmit-data write empties nothing back to set;
- acknowledges drop their requests in the next cycle;
- error bits hold until cleared;
- a slave-select fall yields the end-of-frame pulse;
- a baud tick while off raises the interrupt.

Only the bench scenarios can show the following:
- the exact count of stalled cycles before an abort;
- that the abort sets once per stall;
- how the direction modes mask each output;
- how a simultaneous set and clear resolve on each flag;
- that a timer interrupt leaves every status bit untouched.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_RXONLY = 2'b01,
      MODE_TXONLY = 2'b10,
      MODE_DUPLEX = 2'b11
   } spi_mode_e;

   localparam int NUM_ERR = 5;
   localparam int ERR_OVR = 0;
   localparam int ERR_UND = 1;
   localparam int ERR_COL = 2;
   localparam int ERR_ABT = 3;
   localparam int ERR_SSV = 4;

   function automatic logic tx_dir_on(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic rx_dir_on(input logic [1:0] m);
      return m[0];
   endfunction

endpackage

// File: rtl/spi_stall_timer.sv
module spi_stall_timer #(
   parameter int STALL_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ss_active,
   input  logic sck_edge,
   output logic abort_det
);
   localparam int CNT_W = $clog2(STALL_CYCLES + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_CYCLES);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(STALL_CYCLES - 1);

   logic             stalled;
   logic [CNT_W-1:0] cnt_q;

   assign stalled   = enable && ss_active && !sck_edge;
   assign abort_det = stalled && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!stalled)
         cnt_q <= '0;
      else if (cnt_q != LIMIT)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_flag_bank.sv
module spi_flag_bank #(
   parameter int N_ERR = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             ld_strobe,
   input  logic             txd_wr,
   input  logic             tx_ack,
   input  logic             char_done,
   input  logic             rxd_rd,
   input  logic             rx_ack,
   input  logic [N_ERR-1:0] err_det,
   input  logic [N_ERR-1:0] err_clr,
   output logic             tx_empty,
   output logic             rx_full,
   output logic [N_ERR-1:0] err_flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_empty <= 1'b0;
      else if (!enable || txd_wr || tx_ack)
         tx_empty <= 1'b0;
      else if (ld_strobe)
         tx_empty <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_full <= 1'b0;
      else if (!enable)
         rx_full <= 1'b0;
      else if (char_done)
         rx_full <= 1'b1;
      else if (rxd_rd || rx_ack)
         rx_full <= 1'b0;
   end

   for (genvar i = 0; i < N_ERR; i++) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            err_flags[i] <= 1'b0;
         else if (err_det[i])
            err_flags[i] <= 1'b1;
         else if (err_clr[i])
            err_flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen #(
   parameter int N_SRC = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic             timer_evt,
   output logic             irq
);
   logic [N_SRC-1:0] src_prev_q;
   logic             tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_prev_q <= '0;
         tmr_q      <= 1'b0;
      end else begin
         src_prev_q <= src;
         tmr_q      <= timer_evt;
      end
   end

   assign irq = (|(src & ~src_prev_q)) | tmr_q;
endmodule

// File: rtl/spi_irq_dma_ctl.sv
module spi_irq_dma_ctl
   import spi_irq_pkg::*;
#(
   parameter int STALL_CYCLES = 256,
   parameter bit ABORT_EN     = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode,
   input  logic         data_irq_en,
   input  logic         timer_irq_en,
   input  logic         brg_tick,
   input  logic         txd_wr,
   input  logic         rxd_rd,
   input  logic         ld_strobe,
   input  logic         char_done,
   input  logic         ss_active,
   input  logic         sck_edge,
   input  logic         err_ovr_det,
   input  logic         err_und_det,
   input  logic         err_col_det,
   input  logic         err_ssv_det,
   input  logic [4:0]   err_clr,
   input  logic         tx_ack,
   input  logic         rx_ack,
   output logic         tx_empty,
   output logic         rx_full,
   output logic [4:0]   err_flags,
   output logic         irq,
   output logic         tx_req,
   output logic         rx_req,
   output logic         tx_eof,
   output logic         rx_eof
);
   localparam int N_SRC = NUM_ERR + 2;

   if (STALL_CYCLES < 2) begin : g_bad_stall
      $error("STALL_CYCLES must be at least 2");
   end
   if (NUM_ERR != 5) begin : g_bad_err
      $error("error field width mismatch");
   end

   logic               enabled, tx_on, rx_on;
   logic               abort_det;
   logic [NUM_ERR-1:0] det;
   logic [N_SRC-1:0]   src;
   logic               timer_evt;
   logic               ss_q;
   logic               ss_fall;

   assign enabled = (mode != MODE_OFF);
   assign tx_on   = tx_dir_on(mode);
   assign rx_on   = rx_dir_on(mode);

   if (ABORT_EN) begin : g_stall
      spi_stall_timer #(.STALL_CYCLES(STALL_CYCLES)) u_stall (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (enabled),
         .ss_active (ss_active),
         .sck_edge  (sck_edge),
         .abort_det (abort_det)
      );
   end else begin : g_no_stall
      assign abort_det = 1'b0;
   end

   assign det[ERR_OVR] = enabled && err_ovr_det;
   assign det[ERR_UND] = enabled && err_und_det;
   assign det[ERR_COL] = enabled && err_col_det;
   assign det[ERR_ABT] = abort_det;
   assign det[ERR_SSV] = enabled && err_ssv_det;

   spi_flag_bank #(.N_ERR(NUM_ERR)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enabled),
      .ld_strobe (ld_strobe),
      .txd_wr    (txd_wr),
      .tx_ack    (tx_ack),
      .char_done (char_done),
      .rxd_rd    (rxd_rd),
      .rx_ack    (rx_ack),
      .err_det   (det),
      .err_clr   (err_clr),
      .tx_empty  (tx_empty),
      .rx_full   (rx_full),
      .err_flags (err_flags)
   );

   assign src       = {err_flags,
                       rx_full  && data_irq_en && rx_on,
                       tx_empty && data_irq_en && tx_on};
   assign timer_evt = !enabled && timer_irq_en && brg_tick;

   spi_irq_gen #(.N_SRC(N_SRC)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src),
      .timer_evt (timer_evt),
      .irq       (irq)
   );

   assign ss_fall = ss_q && !ss_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ss_q   <= 1'b0;
         tx_eof <= 1'b0;
         rx_eof <= 1'b0;
      end else begin
         ss_q   <= ss_active;
         tx_eof <= ss_fall && tx_on;
         rx_eof <= ss_fall && rx_on;
      end
   end

   assign tx_req = tx_empty && tx_on;
   assign rx_req = rx_full  && rx_on;
endmodule

// File: rtl/spi_irq_dma_chk.sv
module spi_irq_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       data_irq_en,
   input logic       timer_irq_en,
   input logic       brg_tick,
   input logic       txd_wr,
   input logic       ld_strobe,
   input logic       tx_ack,
   input logic       char_done,
   input logic       rx_ack,
   input logic       ss_active,
   input logic [4:0] err_clr,
   input logic       tx_empty,
   input logic [4:0] err_flags,
   input logic       irq,
   input logic       tx_req,
   input logic       rx_req,
   input logic       tx_eof
);
   // R1
   tx_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && data_irq_en && $rose(tx_empty)) |-> irq);

   // R2
   tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (txd_wr && mode != 2'b00) |=> !tx_empty);

   // R2
   tx_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> !tx_empty);

   // R7
   tx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack && !ld_strobe) |=> !tx_req);

   // R7
   rx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ack && !char_done) |=> !rx_req);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(err_flags & ~err_clr)) |=>
         ((err_flags & $past(err_flags & ~err_clr)) == $past(err_flags & ~err_clr)));

   // R8
   tx_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ss_active) && mode[1]) |=> tx_eof);

   // R9
   timer_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && timer_irq_en && brg_tick) |=> irq);
endmodule

bind spi_irq_dma_ctl spi_irq_dma_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode         (mode),
   .data_irq_en  (data_irq_en),
   .timer_irq_en (timer_irq_en),
   .brg_tick     (brg_tick),
   .txd_wr       (txd_wr),
   .ld_strobe    (ld_strobe),
   .tx_ack       (tx_ack),
   .char_done    (char_done),
   .rx_ack       (rx_ack),
   .ss_active    (ss_active),
   .err_clr      (err_clr),
   .tx_empty     (tx_empty),
   .err_flags    (err_flags),
   .irq          (irq),
   .tx_req       (tx_req),
   .rx_req       (rx_req),
   .tx_eof       (tx_eof)
);

// File: tb/tb_spi_irq_dma_ctl.sv
module tb_spi_irq_dma_ctl;
   localparam int STALL = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       die = 1'b0, tim_en = 1'b0, brg = 1'b0;
   logic       txw = 1'b0, rd = 1'b0, ld = 1'b0, cd = 1'b0;
   logic       ss = 1'b0, sck = 1'b0;
   logic       ovr = 1'b0, und = 1'b0, col = 1'b0, ssv = 1'b0;
   logic [4:0] clr = '0;
   logic       txa = 1'b0, rxa = 1'b0;
   logic       tx_empty, rx_full, irq, tx_req, rx_req, tx_eof, rx_eof;
   logic [4:0] err_flags;

   int checks = 0, failures = 0;
   bit started = 0, done = 0;

   // reference model state
   bit       m_tx, m_rx, m_ss, m_txeof, m_rxeof, m_tmr;
   bit [4:0] m_err;
   bit [6:0] m_prev;
   int       stall_run;

   always #4 clk = ~clk;

   spi_irq_dma_ctl #(.STALL_CYCLES(STALL)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .data_irq_en(die),
      .timer_irq_en(tim_en), .brg_tick(brg), .txd_wr(txw), .rxd_rd(rd),
      .ld_strobe(ld), .char_done(cd), .ss_active(ss), .sck_edge(sck),
      .err_ovr_det(ovr), .err_und_det(und), .err_col_det(col),
      .err_ssv_det(ssv), .err_clr(clr), .tx_ack(txa), .rx_ack(rxa),
      .tx_empty(tx_empty), .rx_full(rx_full), .err_flags(err_flags),
      .irq(irq), .tx_req(tx_req), .rx_req(rx_req), .tx_eof(tx_eof),
      .rx_eof(rx_eof));

   function automatic bit [6:0] sources(bit t, bit r, bit [4:0] e,
                                        logic [1:0] m, logic d);
      return {e, r & d & m[1-1], t & d & m[1]};
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (!rst_n) begin
         m_tx = 0; m_rx = 0; m_ss = 0; m_txeof = 0; m_rxeof = 0;
         m_tmr = 0; m_err = '0; m_prev = '0; stall_run = 0;
      end else begin
         bit en, fall, abt;
         en     = (mode != 2'b00);
         m_prev = sources(m_tx, m_rx, m_err, mode, die);
         m_tmr  = !en && tim_en && brg;
         fall   = m_ss && !ss;
         m_txeof = fall && mode[1];
         m_rxeof = fall && mode[0];
         m_ss   = ss;
         abt = 0;
         if (en && ss && !sck) begin
            stall_run++;
            if (stall_run == STALL) abt = 1;
         end else stall_run = 0;
         if (!en || txw || txa) m_tx = 0;
         else if (ld) m_tx = 1;
         if (!en) m_rx = 0;
         else if (cd) m_rx = 1;
         else if (rd || rxa) m_rx = 0;
         m_err = (m_err & ~clr) |
                 (en ? {ssv, abt, col, und, ovr} : 5'b0);
      end
   end

   task automatic cmp(string what, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%b expected=%b", what, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !done) begin
         bit [6:0] now;
         now = sources(m_tx, m_rx, m_err, mode, die);
         cmp("tx_empty R2 R11", {4'b0, tx_empty}, {4'b0, m_tx});
         cmp("rx_full R3", {4'b0, rx_full}, {4'b0, m_rx});
         cmp("err_flags R5 R6", err_flags, m_err);
         cmp("irq R1 R9 R10", {4'b0, irq},
             {4'b0, (|(now & ~m_prev)) | m_tmr});
         cmp("tx_req R7 R4", {4'b0, tx_req}, {4'b0, m_tx & mode[1]});
         cmp("rx_req R7 R4", {4'b0, rx_req}, {4'b0, m_rx & mode[0]});
         cmp("tx_eof R8 R4", {4'b0, tx_eof}, {4'b0, m_txeof});
         cmp("rx_eof R8 R4", {4'b0, rx_eof}, {4'b0, m_rxeof});
      end
   end

   task automatic go(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         ld = 0; txw = 0; txa = 0; cd = 0; rd = 0; rxa = 0; sck = 0;
         ovr = 0; und = 0; col = 0; ssv = 0; clr = '0; brg = 0;
      end
   endtask

   initial begin
      #(8 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      go(3);
      rst_n = 1; go(2);
      // R2 R1 R7 full duplex transmit path
      mode = 2'b11; die = 1; go(2);
      txw = 1; go(1);
      ld = 1; go(3);
      txa = 1; go(2);
      ld = 1; txw = 1; go(2);          // clear wins on tx_empty
      ld = 1; go(2);
      txw = 1; go(2);
      // R3 receive path, set wins
      cd = 1; go(2);
      rxa = 1; go(2);
      cd = 1; go(1);
      cd = 1; rd = 1; go(2);
      rd = 1; go(2);
      // R6 stall then R8 end of frame
      ss = 1; go(1);
      for (int k = 0; k < 4; k++) begin sck = 1; go(2); end
      go(STALL + 3);
      clr = 5'b01000; go(3);
      ss = 0; go(3);
      // R5 errors, clear together with detection
      ovr = 1; und = 1; go(2);
      col = 1; ssv = 1; clr = 5'b00011; go(2);
      ovr = 1; clr = 5'b00001; go(2);
      clr = 5'b11111; go(2);
      // R4 R11 receive-only
      mode = 2'b01; go(2);
      ld = 1; go(2);
      cd = 1; go(2);
      ss = 1; go(2); ss = 0; go(3);
      rxa = 1; go(2);
      // R4 transmit-only
      mode = 2'b10; go(2);
      ld = 1; cd = 1; go(2);
      ss = 1; go(2); ss = 0; go(3);
      // R10 data interrupts masked, errors still fire
      die = 0; mode = 2'b11; txw = 1; go(1);
      ld = 1; cd = 1; go(2);
      und = 1; go(2);
      die = 1; go(2);
      clr = 5'b11111; go(2);
      // R9 timer while off
      mode = 2'b00; go(2);
      brg = 1; go(2);
      tim_en = 1; brg = 1; go(2);
      brg = 1; go(1); brg = 1; go(2);
      mode = 2'b11; brg = 1; go(2);
      go(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule